// File: doc/BRIEF.md
# Signature-Driven Faulty-Row Locator for a Column-Multiplexed ROM

This controller runs a built-in diagnosis of a column-multiplexed ROM. It treats each low-order column index as a small ROM of its own. For that column it reads all rows once. Each word is folded into a toggle register and into a Galois multiple-input signature register (MISR). Before the sweep, both registers are seeded from two spare signature rows in the ROM. If the toggle residue after the sweep is zero, the column is clean. If the residue is nonzero, the controller runs the MISR backwards one step per clock while a row counter counts down from the last row. The row at which the MISR equals the toggle residue is the faulty row. The controller then issues one repair write that carries the faulty address and the corrected word.

After every column has been handled, a second pass reads the array again. In this pass the data arrives through the external repair buffer. Any residue found in the second pass ends the run with the failure status raised. The same status is raised when the countdown reaches row 0 without a match.

The ROM read port is combinational: the word for `rom_addr` is expected on `rom_data` in the same cycle. The word must already include any substitution made by the repair buffer.

Top module: `rom_row_locator`

## Requirements
- R1: `rom_addr` is `{ext, row, col}`, with the column index in the low COL_BITS bits and `ext` in the top bit. When `ext` is 1, row field 0 selects the MISR seed of column `col` and row field 1 selects its toggle seed. Each column's work starts with the MISR seed read and then the toggle seed read, on consecutive cycles.
- R2: After the seed reads, rows 0 through 2^ROW_BITS-1 of the column are read in ascending order, one per cycle, with `ext`=0 and `rom_en`=1. Columns are visited in ascending order, starting from 0.
- R3: Each swept word is XORed into the toggle register. The MISR steps as m' = ((m<<1) ^ (m[MSB] ? POLY : 0)) ^ word. One cycle with `rom_en`=0 follows the sweep while the residue is examined.
- R4: In the first pass, a zero toggle residue means the column is clean: no repair write is made and the next column's seed reads follow at once.
- R5: In the first pass, a nonzero toggle residue starts a locate phase. Each cycle of this phase compares the MISR with the toggle register, starting at the last row. On a mismatch, the MISR takes one reverse step (the inverse of the R3 shift with no data) and the row counter decrements. `rom_en` stays 0 during this phase.
- R6: On a match, exactly one cycle asserts `rep_we` and `rom_en`. That cycle sets `rom_addr`={0,row,col} and `rep_addr`={row,col}. It also sets `rep_data` to the word read there XORed with the toggle residue, which for a single faulty word is the fault-free word.
- R7: If row 0 is compared without a match, no repair write is made and the run ends with `done`=1 and `repair_fail`=1 in the next cycle.
- R8: After the last column of the first pass, all columns are processed again in the same order. In this second pass no locating is done. A nonzero toggle or MISR residue ends the run with `done`=1 and `repair_fail`=1 in the cycle after the check.
- R9: When the second pass completes with no residue, `done`=1 and `repair_fail`=0. `done` and `repair_fail` hold until a new `start` restarts the procedure from column 0 of the first pass.
- R10: `start` has no effect while a run is in progress.
- R11: After reset, `done`, `repair_fail`, `rom_en` and `rep_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or done |
| rom_en | output | 1 | A ROM read is in progress this cycle |
| rom_addr | output | ROW_BITS+COL_BITS+1 | `{ext, row, col}` read address |
| rom_data | input | DATA_W | Word at `rom_addr`, with repair substitution applied |
| rep_we | output | 1 | Repair-buffer write strobe |
| rep_addr | output | ROW_BITS+COL_BITS | Faulty word address `{row, col}` |
| rep_data | output | DATA_W | Corrected word |
| done | output | 1 | Run finished |
| repair_fail | output | 1 | Run ended without a clean second pass |

## Verification
The hardest state to reach from the ports is a locate phase that runs all the way down to row 0 without a match. No plain data fault can produce it, because a single bad word always matches somewhere. The stimulus reaches it by corrupting only the toggle seed of one column. The toggle residue is then nonzero while the MISR residue stays zero, so the comparison fails at every row. A separate case corrupts only the MISR seed. That column passes the first pass and fails only the second-pass MISR check. Faults at the last row and at row 0 exercise both ends of the countdown.

// File: rtl/rrl_pkg.sv
package rrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED_M,
      ST_SEED_T,
      ST_SWEEP,
      ST_CHECK,
      ST_LOCATE,
      ST_FIX,
      ST_DONE
   } rrl_state_e;

   typedef enum logic [2:0] {
      SG_HOLD,
      SG_LOAD_M,
      SG_LOAD_T,
      SG_ACCUM,
      SG_REWIND
   } rrl_sig_op_e;

endpackage

// File: rtl/rrl_addr_gen.sv
module rrl_addr_gen #(
   parameter int ROW_BITS = 4,
   parameter int COL_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                col_clr,
   input  logic                col_inc,
   input  logic                row_clr,
   input  logic                row_inc,
   input  logic                row_dec,
   output logic [ROW_BITS-1:0] row,
   output logic [COL_BITS-1:0] col,
   output logic                row_top,
   output logic                row_bot,
   output logic                col_top
);

   localparam logic [ROW_BITS-1:0] ROW_MAX = {ROW_BITS{1'b1}};
   localparam logic [COL_BITS-1:0] COL_MAX = {COL_BITS{1'b1}};

   // row counter: counts up during a sweep, down while locating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (row_clr) begin
         row <= '0;
      end else if (row_inc) begin
         row <= row + ROW_BITS'(1);
      end else if (row_dec) begin
         row <= row - ROW_BITS'(1);
      end
   end

   // column counter: one step per processed column
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (col_clr) begin
         col <= '0;
      end else if (col_inc) begin
         col <= col + COL_BITS'(1);
      end
   end

   assign row_top = (row == ROW_MAX);
   assign row_bot = (row == '0);
   assign col_top = (col == COL_MAX);

endmodule

// File: rtl/rrl_sig_unit.sv
module rrl_sig_unit
   import rrl_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] POLY   = 8'h1D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rrl_sig_op_e       op,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] tog,
   output logic [DATA_W-1:0] misr,
   output logic              match,
   output logic              tog_zero,
   output logic              misr_zero
);

   logic [DATA_W-1:0] fwd_nx;
   logic [DATA_W-1:0] rev_nx;

   // forward: multiply by x modulo the feedback polynomial
   // reverse: the exact inverse, i.e. a right shift with reciprocal taps
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_fwd_lo
         assign fwd_nx[i] = POLY[i] & misr[DATA_W-1];
      end else begin : g_fwd_hi
         assign fwd_nx[i] = misr[i-1] ^ (POLY[i] & misr[DATA_W-1]);
      end
      if (i == DATA_W-1) begin : g_rev_top
         assign rev_nx[i] = misr[0];
      end else begin : g_rev_rest
         assign rev_nx[i] = misr[i+1] ^ (POLY[i+1] & misr[0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog  <= '0;
         misr <= '0;
      end else begin
         unique case (op)
            SG_LOAD_M: misr <= din;
            SG_LOAD_T: tog  <= din;
            SG_ACCUM: begin
               tog  <= tog ^ din;
               misr <= fwd_nx ^ din;
            end
            SG_REWIND: misr <= rev_nx;
            default: ;
         endcase
      end
   end

   assign match     = (misr == tog);
   assign tog_zero  = (tog == '0);
   assign misr_zero = (misr == '0);

endmodule

// File: rtl/rrl_ctrl.sv
module rrl_ctrl
   import rrl_pkg::*;
#(
   parameter bit FINAL_MISR_CHECK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        row_top,
   input  logic        row_bot,
   input  logic        col_top,
   input  logic        match,
   input  logic        tog_zero,
   input  logic        misr_zero,
   output logic        col_clr,
   output logic        col_inc,
   output logic        row_clr,
   output logic        row_inc,
   output logic        row_dec,
   output rrl_sig_op_e sig_op,
   output logic        rom_en,
   output logic        seed_rd,
   output logic        seed_sel,
   output logic        rep_we,
   output logic        done,
   output logic        fail
);

   rrl_state_e st_q, st_d;
   logic       pass_q, pass_d;
   logic       fail_q, fail_d;
   logic       adv;
   logic       residue_bad;

   // choose what counts as a residue in the retest pass
   if (FINAL_MISR_CHECK) begin : g_both
      assign residue_bad = !tog_zero || !misr_zero;
   end else begin : g_tog_only
      logic unused_misr;
      assign unused_misr = misr_zero;
      assign residue_bad = !tog_zero;
   end

   always_comb begin
      st_d     = st_q;
      pass_d   = pass_q;
      fail_d   = fail_q;
      col_clr  = 1'b0;
      col_inc  = 1'b0;
      row_clr  = 1'b0;
      row_inc  = 1'b0;
      row_dec  = 1'b0;
      sig_op   = SG_HOLD;
      rom_en   = 1'b0;
      seed_rd  = 1'b0;
      seed_sel = 1'b0;
      rep_we   = 1'b0;
      adv      = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               st_d    = ST_SEED_M;
               pass_d  = 1'b0;
               fail_d  = 1'b0;
               col_clr = 1'b1;
            end
         end
         ST_SEED_M: begin
            rom_en  = 1'b1;
            seed_rd = 1'b1;
            sig_op  = SG_LOAD_M;
            st_d    = ST_SEED_T;
         end
         ST_SEED_T: begin
            rom_en   = 1'b1;
            seed_rd  = 1'b1;
            seed_sel = 1'b1;
            sig_op   = SG_LOAD_T;
            row_clr  = 1'b1;
            st_d     = ST_SWEEP;
         end
         ST_SWEEP: begin
            rom_en = 1'b1;
            sig_op = SG_ACCUM;
            if (row_top) st_d = ST_CHECK;
            else         row_inc = 1'b1;
         end
         ST_CHECK: begin
            if (pass_q) begin
               if (residue_bad) begin
                  fail_d = 1'b1;
                  st_d   = ST_DONE;
               end else begin
                  adv = 1'b1;
               end
            end else if (tog_zero) begin
               adv = 1'b1;
            end else begin
               st_d = ST_LOCATE;
            end
         end
         ST_LOCATE: begin
            if (match) begin
               st_d = ST_FIX;
            end else if (row_bot) begin
               fail_d = 1'b1;
               st_d   = ST_DONE;
            end else begin
               sig_op  = SG_REWIND;
               row_dec = 1'b1;
            end
         end
         ST_FIX: begin
            rom_en = 1'b1;
            rep_we = 1'b1;
            adv    = 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase

      if (adv) begin
         if (!col_top) begin
            col_inc = 1'b1;
            st_d    = ST_SEED_M;
         end else if (!pass_q) begin
            pass_d  = 1'b1;
            col_clr = 1'b1;
            st_d    = ST_SEED_M;
         end else begin
            st_d = ST_DONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pass_q <= pass_d;
         fail_q <= fail_d;
      end
   end

   assign done = (st_q == ST_DONE);
   assign fail = fail_q;

   AST_WRAP_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCATE && !match && row_bot) |=> (done && fail)) else $error("wrap without fail"); // R7
   AST_HIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCATE && match) |=> rep_we) else $error("match without repair write"); // R5
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(fail))) else $error("done dropped"); // R9
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SWEEP && start && !row_top) |=> (st_q == ST_SWEEP)) else $error("start disturbed run"); // R10
   AST_RETEST_NO_LOCATE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_q |-> (st_q != ST_LOCATE && !rep_we)) else $error("locate in retest"); // R8

endmodule

// File: rtl/rom_row_locator.sv
module rom_row_locator
   import rrl_pkg::*;
#(
   parameter int                ROW_BITS         = 4,
   parameter int                COL_BITS         = 2,
   parameter int                DATA_W           = 8,
   parameter logic [DATA_W-1:0] POLY             = 8'h1D,
   parameter bit                FINAL_MISR_CHECK = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   output logic                         rom_en,
   output logic [ROW_BITS+COL_BITS:0]   rom_addr,
   input  logic [DATA_W-1:0]            rom_data,
   output logic                         rep_we,
   output logic [ROW_BITS+COL_BITS-1:0] rep_addr,
   output logic [DATA_W-1:0]            rep_data,
   output logic                         done,
   output logic                         repair_fail
);

   localparam int ADDR_W = ROW_BITS + COL_BITS + 1;

   // elaboration checks
   if (ROW_BITS < 1) begin : g_chk_rows
      $error("ROW_BITS must be at least 1 (two seed rows are needed)");
   end
   if (COL_BITS < 1) begin : g_chk_cols
      $error("COL_BITS must be at least 1");
   end
   if (DATA_W <= ROW_BITS) begin : g_chk_period
      $error("DATA_W must exceed ROW_BITS so the MISR period covers every row");
   end
   if (POLY[0] != 1'b1) begin : g_chk_poly
      $error("POLY must have its constant term set for the reverse step");
   end

   logic                col_clr, col_inc, row_clr, row_inc, row_dec;
   logic [ROW_BITS-1:0] row;
   logic [COL_BITS-1:0] col;
   logic                row_top, row_bot, col_top;
   rrl_sig_op_e         sig_op;
   logic [DATA_W-1:0]   tog, misr;
   logic                match, tog_zero, misr_zero;
   logic                seed_rd, seed_sel;

   rrl_addr_gen #(
      .ROW_BITS(ROW_BITS),
      .COL_BITS(COL_BITS)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .col_clr(col_clr),
      .col_inc(col_inc),
      .row_clr(row_clr),
      .row_inc(row_inc),
      .row_dec(row_dec),
      .row    (row),
      .col    (col),
      .row_top(row_top),
      .row_bot(row_bot),
      .col_top(col_top)
   );

   rrl_sig_unit #(
      .DATA_W(DATA_W),
      .POLY  (POLY)
   ) u_sig (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (sig_op),
      .din      (rom_data),
      .tog      (tog),
      .misr     (misr),
      .match    (match),
      .tog_zero (tog_zero),
      .misr_zero(misr_zero)
   );

   rrl_ctrl #(
      .FINAL_MISR_CHECK(FINAL_MISR_CHECK)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .row_top  (row_top),
      .row_bot  (row_bot),
      .col_top  (col_top),
      .match    (match),
      .tog_zero (tog_zero),
      .misr_zero(misr_zero),
      .col_clr  (col_clr),
      .col_inc  (col_inc),
      .row_clr  (row_clr),
      .row_inc  (row_inc),
      .row_dec  (row_dec),
      .sig_op   (sig_op),
      .rom_en   (rom_en),
      .seed_rd  (seed_rd),
      .seed_sel (seed_sel),
      .rep_we   (rep_we),
      .done     (done),
      .fail     (repair_fail)
   );

   // seed rows sit above the data array, selected by the extra top bit
   assign rom_addr = seed_rd ? {1'b1, ROW_BITS'(seed_sel), col} : {1'b0, row, col};
   assign rep_addr = {row, col};
   assign rep_data = rom_data ^ tog;

   AST_FIX_RESIDUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rep_we |-> (misr == tog && rom_en && !rom_addr[ADDR_W-1])) else $error("repair without match"); // R6
   AST_SWEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_en && !rom_addr[ADDR_W-1] && !rep_we && !row_top)
      |=> (rom_en && !rom_addr[ADDR_W-1] && row == $past(row) + ROW_BITS'(1) && $stable(col))) else $error("sweep order"); // R2
   AST_SEED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_rd && !seed_sel) |=> (seed_rd && seed_sel && $stable(col))) else $error("seed order"); // R1

endmodule

// File: tb/rom_row_locator_tb.sv
module rom_row_locator_tb;

   localparam int RB = 4;
   localparam int CB = 2;
   localparam int DW = 8;
   localparam logic [DW-1:0] PL = 8'h1D;
   localparam int NR = 1 << RB;
   localparam int NC = 1 << CB;
   localparam int NA = NR * NC;
   localparam int AW = RB + CB + 1;
   localparam int EW = 3 + AW + 1 + (RB + CB) + DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic            rom_en;
   logic [AW-1:0]   rom_addr;
   logic [DW-1:0]   rom_data;
   logic            rep_we;
   logic [RB+CB-1:0] rep_addr;
   logic [DW-1:0]   rep_data;
   logic            done;
   logic            repair_fail;

   always #2ns clk = ~clk;

   rom_row_locator u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rom_en     (rom_en),
      .rom_addr   (rom_addr),
      .rom_data   (rom_data),
      .rep_we     (rep_we),
      .rep_addr   (rep_addr),
      .rep_data   (rep_data),
      .done       (done),
      .repair_fail(repair_fail)
   );

   // ROM contents, seeds and the repair buffer of the environment
   logic [DW-1:0] gold [NA];
   logic [DW-1:0] base [NA];
   logic [DW-1:0] sigm [NC];
   logic [DW-1:0] sigt [NC];
   logic          rb_v [NA];
   logic [DW-1:0] rb_d [NA];
   logic          rb_clr = 1'b0;

   // model-side repair map
   logic          mv [NA];
   logic [DW-1:0] md [NA];

   int tests = 0;
   int fails = 0;
   bit single = 1'b0;
   bit finished = 1'b0;

   logic [EW-1:0] tq [$];
   string         tg [$];

   always_comb begin
      if (rom_addr[AW-1]) begin
         if (rom_addr[RB+CB-1:CB] == RB'(0))      rom_data = sigm[rom_addr[CB-1:0]];
         else if (rom_addr[RB+CB-1:CB] == RB'(1)) rom_data = sigm[rom_addr[CB-1:0]] ^ sigm[rom_addr[CB-1:0]] ^ sigt[rom_addr[CB-1:0]];
         else                                     rom_data = '0;
      end else if (rb_v[rom_addr[RB+CB-1:0]]) begin
         rom_data = rb_d[rom_addr[RB+CB-1:0]];
      end else begin
         rom_data = base[rom_addr[RB+CB-1:0]];
      end
   end

   always @(posedge clk) begin
      if (rb_clr) begin
         for (int i = 0; i < NA; i++) rb_v[i] <= 1'b0;
      end else if (rep_we) begin
         rb_v[rep_addr] <= 1'b1;
         rb_d[rep_addr] <= rep_data;
      end
   end

   function automatic logic [DW-1:0] fwd(input logic [DW-1:0] m, input logic [DW-1:0] d);
      logic [DW-1:0] s;
      s = m << 1;
      if (m[DW-1]) s = s ^ PL;
      return s ^ d;
   endfunction

   function automatic logic [DW-1:0] rev(input logic [DW-1:0] m);
      logic [DW-1:0] s;
      if (m[0]) s = ((m ^ PL) >> 1) | {1'b1, {(DW-1){1'b0}}};
      else      s = m >> 1;
      return s;
   endfunction

   task automatic push(input logic dn, input logic fl, input logic en, input logic [AW-1:0] ad,
                       input logic we, input logic [RB+CB-1:0] wa, input logic [DW-1:0] wd, input string t);
      tq.push_back({dn, fl, en, en ? ad : {AW{1'b0}}, we, we ? wa : {(RB+CB){1'b0}}, we ? wd : {DW{1'b0}}});
      tg.push_back(t);
   endtask

   // behavioural reference: expected per-cycle outputs of one whole run
   task automatic build();
      logic [DW-1:0] m, t, d;
      int r, a;
      bit found;
      string tagc;
      tq.delete();
      tg.delete();
      for (int i = 0; i < NA; i++) mv[i] = 1'b0;
      tagc = "R1";
      for (int p = 0; p < 2; p++) begin
         for (int c = 0; c < NC; c++) begin
            push(0, 0, 1, {1'b1, RB'(0), CB'(c)}, 0, '0, '0, tagc);
            push(0, 0, 1, {1'b1, RB'(1), CB'(c)}, 0, '0, '0, "R1");
            m = sigm[c];
            t = sigt[c];
            for (int rr = 0; rr < NR; rr++) begin
               a = rr * NC + c;
               d = mv[a] ? md[a] : base[a];
               t = t ^ d;
               m = fwd(m, d);
               push(0, 0, 1, {1'b0, (RB+CB)'(a)}, 0, '0, '0, "R2");
            end
            push(0, 0, 0, '0, 0, '0, '0, "R3");
            tagc = "R1";
            if (p == 1) begin
               if (t != '0 || m != '0) begin
                  push(1, 1, 0, '0, 0, '0, '0, "R8");
                  return;
               end
               tagc = "R8";
            end else if (t == '0) begin
               tagc = "R4";
            end else begin
               r = NR - 1;
               found = 1'b0;
               forever begin
                  push(0, 0, 0, '0, 0, '0, '0, "R5");
                  if (m == t) begin
                     found = 1'b1;
                     break;
                  end
                  if (r == 0) break;
                  m = rev(m);
                  r = r - 1;
               end
               if (!found) begin
                  push(1, 1, 0, '0, 0, '0, '0, "R7");
                  return;
               end
               a = r * NC + c;
               push(0, 0, 1, {1'b0, (RB+CB)'(a)}, 1, (RB+CB)'(a), base[a] ^ t, "R6");
               mv[a] = 1'b1;
               md[a] = base[a] ^ t;
            end
         end
      end
      push(1, 0, 0, '0, 0, '0, '0, "R9");
   endtask

   task automatic compute_seeds();
      logic [DW-1:0] m, t;
      for (int c = 0; c < NC; c++) begin
         m = '0;
         t = '0;
         for (int r = 0; r < NR; r++) begin
            t = t ^ gold[r * NC + c];
            m = fwd(m, gold[r * NC + c]);
         end
         for (int r = 0; r < NR; r++) m = rev(m);
         sigm[c] = m;
         sigt[c] = t;
      end
   endtask

   task automatic cmp(input logic [EW-1:0] e, input string t);
      logic [EW-1:0] o;
      o = {done, repair_fail, rom_en, rom_en ? rom_addr : {AW{1'b0}},
           rep_we, rep_we ? rep_addr : {(RB+CB){1'b0}}, rep_we ? rep_data : {DW{1'b0}}};
      tests++;
      if (o !== e) begin
         fails++;
         $display("FAIL %s: outputs %h expected %h", t, o, e);
      end
      if (rep_we && single) begin
         tests++;
         if (rep_data !== gold[rep_addr]) begin
            fails++;
            $display("FAIL R6: corrected word %h expected %h at %0d", rep_data, gold[rep_addr], rep_addr);
         end
      end
   endtask

   task automatic run_case(input bit pulse_mid);
      logic [EW-1:0] last;
      int k;
      @(negedge clk);
      rb_clr = 1'b1;
      @(negedge clk);
      rb_clr = 1'b0;
      build();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      last = '0;
      while (tq.size() > 0) begin
         last = tq.pop_front();
         if (pulse_mid && k == 21) cmp(last, "R10");
         else                      cmp(last, tg.pop_front());
         if (pulse_mid && k == 21) void'(tg.pop_front());
         start = (pulse_mid && k == 20);
         k++;
         @(negedge clk);
      end
      start = 1'b0;
      tests++;
      if (done !== 1'b1 || repair_fail !== last[EW-2]) begin
         fails++;
         $display("FAIL R9: done/fail %b%b expected 1%b", done, repair_fail, last[EW-2]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R9: watchdog expired, done=%b expected 1", done);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < NA; a++) begin
         gold[a] = DW'(a * 29 + 7) ^ DW'(a >> 1) ^ 8'h5A;
         base[a] = gold[a];
         rb_v[a] = 1'b0;
         rb_d[a] = '0;
      end
      compute_seeds();

      // R11: reset state
      repeat (3) @(negedge clk);
      tests++;
      if ({done, repair_fail, rom_en, rep_we} !== 4'b0000) begin
         fails++;
         $display("FAIL R11: outputs %b expected 0000", {done, repair_fail, rom_en, rep_we});
      end
      rst_n = 1'b1;

      // clean array: every column passes both sweeps (R4, R9)
      single = 1'b1;
      run_case(1'b0);

      // one bad word in three columns, incl. last row and row 0, start pulsed mid-run (R5, R6, R10)
      base[5 * NC + 1]  = gold[5 * NC + 1] ^ 8'h04;
      base[15 * NC + 3] = gold[15 * NC + 3] ^ 8'hA5;
      base[0 * NC + 0]  = gold[0 * NC + 0] ^ 8'h80;
      run_case(1'b1);
      for (int a = 0; a < NA; a++) base[a] = gold[a];

      // corrupted toggle seed: locate runs to row 0 without a match (R7)
      single = 1'b0;
      sigt[2] = sigt[2] ^ 8'h3C;
      run_case(1'b0);
      compute_seeds();

      // corrupted MISR seed: clean first pass, retest flags the column (R8)
      sigm[1] = sigm[1] ^ 8'h11;
      run_case(1'b0);
      compute_seeds();

      // restart after a failed run, fault in a middle row (R9, R6)
      single = 1'b1;
      base[7 * NC + 2] = gold[7 * NC + 2] ^ 8'hFF;
      run_case(1'b0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule